// File: doc/BRIEF.md
# Floppy Drive Sense Multiplexer

This block sits between a host disk controller and the firmware of a floppy drive emulator. It drives the single sense line that the host reads. The host picks what it reads by setting four lines: a head-select line and the three lower phase lines. Together they form a 4-bit register address. Most addresses return one stored bit from a bank of sixteen one-bit drive-state registers. Three addresses instead pass a live stream straight through: the motor tachometer, read data from side 0, or read data from side 1.

The route from the address lines to the sense line has no registers in it, so the output follows an address change within gate delays. Firmware loads the state bits through a synchronous write port. It can see which address is selected, so it knows which side's data to stream.

A rising edge on the fourth phase line acts as a write strobe. The block synchronises this line together with the address. On the strobe it captures the address into a 4-bit latch and pulses a one-cycle flag toward the firmware. Output enable and level shifting are done outside the block.

Top module: `drive_sense_mux`

## Requirements
- R1: The selected address `addr_o` is formed with no clock: bit 0 is `head_sel_i`, and bits 1, 2 and 3 are `phase_i[0]`, `phase_i[1]` and `phase_i[2]`.
- R2: For any address other than 7, 8 and 9, `sense_o` equals the stored register bit at that address.
- R3: At address 7, `sense_o` equals `tach_i`.
- R4: At address 8, `sense_o` equals `rd_side0_i`.
- R5: At address 9, `sense_o` equals `rd_side1_i`.
- R6: `sense_o` follows a change of the address lines or of the selected stream without waiting for a clock edge.
- R7: With `fw_we_i` high at a rising clock edge, register `fw_idx_i` takes `fw_bit_i`. The new value is visible on `sense_o` from the next cycle on.
- R8: After reset, all sixteen register bits, `wlatch_o` and `wstrobe_o` are 0.
- R9: A rising edge on `phase_i[3]` loads the address present with it into `wlatch_o`. `wstrobe_o` is high for exactly one cycle, within SYNC_STAGES+1 cycles.
- R10: A falling edge on `phase_i[3]`, or holding it steady, causes no strobe and leaves `wlatch_o` unchanged.
- R11: While `fw_we_i` is low, changes on `fw_idx_i` and `fw_bit_i` leave every register bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_sel_i | input | 1 | Head-select line, address bit 0 |
| phase_i | input | 4 | Phase lines; [2:0] address bits 3:1, [3] write strobe |
| tach_i | input | 1 | Live motor tachometer stream |
| rd_side0_i | input | 1 | Live read data, side 0 |
| rd_side1_i | input | 1 | Live read data, side 1 |
| fw_we_i | input | 1 | Firmware register write enable |
| fw_idx_i | input | 4 | Firmware register index |
| fw_bit_i | input | 1 | Firmware register data bit |
| sense_o | output | 1 | Sense line to the host |
| addr_o | output | 4 | Currently selected address |
| wlatch_o | output | 4 | Address captured on the last strobe |
| wstrobe_o | output | 1 | One-cycle flag for a captured strobe |

## Verification
The bench sweeps all sixteen addresses against all eight combinations of the three streams, under two complementary register patterns. A stored bit that was routed wrongly, or a stream mapped to the wrong address, therefore shows up as a mismatch. Addresses and streams change between clock edges, which separates a combinational route from a registered one. Strobe tests use several addresses, rising and falling edges, and writes with the enable low. These tell a real edge capture apart from level sensing or a stuck latch.

// File: rtl/sense_pkg.sv
package sense_pkg;
    localparam int ADDR_W     = 4;
    localparam int TACH_ADDR  = 7;
    localparam int SIDE0_ADDR = 8;
    localparam int SIDE1_ADDR = 9;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_TACH  = 2'd1,
        SRC_SIDE0 = 2'd2,
        SRC_SIDE1 = 2'd3
    } src_e;
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/sense_regfile.sv
module sense_regfile #(
    parameter int ADDR_W = 4,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] widx_i,
    input  logic              wbit_i,
    input  logic [ADDR_W-1:0] ridx_i,
    output logic              rbit_o
);
    typedef struct packed {
        logic [NREG-1:0] bits;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we_i) rf_d.bits[widx_i] = wbit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rbit_o = rf_q.bits[ridx_i];
endmodule

// File: rtl/sense_route.sv
module sense_route
    import sense_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              reg_bit_i,
    input  logic              tach_i,
    input  logic              side0_i,
    input  logic              side1_i,
    output logic              sense_o
);
    src_e src;

    always_comb begin
        unique case (int'(addr_i))
            TACH_ADDR:  src = SRC_TACH;
            SIDE0_ADDR: src = SRC_SIDE0;
            SIDE1_ADDR: src = SRC_SIDE1;
            default:    src = SRC_REG;
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_TACH:  sense_o = tach_i;
            SRC_SIDE0: sense_o = side0_i;
            SRC_SIDE1: sense_o = side1_i;
            default:   sense_o = reg_bit_i;
        endcase
    end
endmodule

// File: rtl/strobe_latch.sv
module strobe_latch #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_line_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] latch_o,
    output logic              pulse_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] latch;
        logic              pulse;
        logic              prev;
    } sl_t;

    sl_t sl_d, sl_q;

    always_comb begin
        sl_d       = sl_q;
        sl_d.prev  = strobe_line_i;
        sl_d.pulse = strobe_line_i & ~sl_q.prev;
        if (strobe_line_i & ~sl_q.prev) sl_d.latch = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign latch_o = sl_q.latch;
    assign pulse_o = sl_q.pulse;
endmodule

// File: rtl/drive_sense_mux.sv
module drive_sense_mux
    import sense_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_sel_i,
    input  logic [3:0]        phase_i,
    input  logic              tach_i,
    input  logic              rd_side0_i,
    input  logic              rd_side1_i,
    input  logic              fw_we_i,
    input  logic [ADDR_W-1:0] fw_idx_i,
    input  logic              fw_bit_i,
    output logic              sense_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] wlatch_o,
    output logic              wstrobe_o
);
    localparam int SYNC_W = ADDR_W + 1;

    logic              reg_bit;
    logic [SYNC_W-1:0] sync_q;

    assign addr_o = {phase_i[2:0], head_sel_i};

    sense_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (fw_we_i),
        .widx_i (fw_idx_i),
        .wbit_i (fw_bit_i),
        .ridx_i (addr_o),
        .rbit_o (reg_bit)
    );

    sense_route #(.ADDR_W(ADDR_W)) u_route (
        .addr_i    (addr_o),
        .reg_bit_i (reg_bit),
        .tach_i    (tach_i),
        .side0_i   (rd_side0_i),
        .side1_i   (rd_side1_i),
        .sense_o   (sense_o)
    );

    sense_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({phase_i[3], addr_o}),
        .q_o   (sync_q)
    );

    strobe_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_line_i (sync_q[SYNC_W-1]),
        .addr_i        (sync_q[ADDR_W-1:0]),
        .latch_o       (wlatch_o),
        .pulse_o       (wstrobe_o)
    );
endmodule

// File: rtl/sense_mux_chk.sv
module sense_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] addr_o,
    input logic       sense_o,
    input logic       tach_i,
    input logic       rd_side0_i,
    input logic       rd_side1_i,
    input logic [3:0] wlatch_o,
    input logic       wstrobe_o
);
    // R3
    tach_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o == 4'd7) |-> (sense_o == tach_i));
    // R4
    side0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o == 4'd8) |-> (sense_o == rd_side0_i));
    // R5
    side1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o == 4'd9) |-> (sense_o == rd_side1_i));
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wstrobe_o |=> !wstrobe_o);
    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wstrobe_o |-> $stable(wlatch_o));
endmodule

bind drive_sense_mux sense_mux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_o     (addr_o),
    .sense_o    (sense_o),
    .tach_i     (tach_i),
    .rd_side0_i (rd_side0_i),
    .rd_side1_i (rd_side1_i),
    .wlatch_o   (wlatch_o),
    .wstrobe_o  (wstrobe_o)
);

// File: tb/tb_drive_sense_mux.sv
module tb_drive_sense_mux;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       head_sel_i = 0;
    logic [3:0] phase_i = 0;
    logic       tach_i = 0, rd_side0_i = 0, rd_side1_i = 0;
    logic       fw_we_i = 0;
    logic [3:0] fw_idx_i = 0;
    logic       fw_bit_i = 0;
    logic       sense_o;
    logic [3:0] addr_o, wlatch_o;
    logic       wstrobe_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    drive_sense_mux dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_addr(input int a);
        head_sel_i   = a[0];
        phase_i[2:0] = a[3:1];
    endtask

    task automatic fw_write(input int idx, input bit b);
        @(negedge clk);
        fw_we_i = 1; fw_idx_i = idx[3:0]; fw_bit_i = b;
        @(negedge clk);
        fw_we_i = 0;
    endtask

    function automatic bit pat(input int mode, input int a);
        return mode[0] ^ (a[0] ^ a[1] ^ a[2] ^ a[3]);
    endfunction

    // R1 R2 R3 R4 R5 R6: sweep between clock edges
    task automatic sweep(input int mode, input string tag);
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 8; s++) begin
                int exp;
                #1; set_addr(a);
                tach_i = s[0]; rd_side0_i = s[1]; rd_side1_i = s[2];
                #1;
                if (a == 7)      exp = s[0];
                else if (a == 8) exp = s[1];
                else if (a == 9) exp = s[2];
                else             exp = pat(mode, a);
                check(tag, sense_o, exp);
                if (s == 0) check("R1", addr_o, a);
            end
        end
    endtask

    task automatic strobe_count(output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wstrobe_o) n++;
        end
    endtask

    initial begin
        int n;
        #23;
        check("R8", wstrobe_o, 0);
        check("R8", wlatch_o, 0);
        rst_n = 1;
        // R8: all registers read 0
        for (int a = 0; a < 16; a++) begin
            if (a >= 7 && a <= 9) continue;
            set_addr(a); #1;
            check("R8", sense_o, 0);
        end
        // R7: load parity pattern
        for (int a = 0; a < 16; a++) fw_write(a, pat(0, a));
        sweep(0, "R2");
        // R11: enable low, toggle index and data
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            fw_idx_i = a[3:0]; fw_bit_i = ~pat(0, a);
        end
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            if (a >= 7 && a <= 9) continue;
            set_addr(a); #1;
            check("R11", sense_o, pat(0, a));
        end
        // R7: inverse pattern, visible the cycle after the write
        for (int a = 0; a < 16; a++) begin
            fw_write(a, pat(1, a));
            if (a >= 7 && a <= 9) continue;
            set_addr(a); #1;
            check("R7", sense_o, pat(1, a));
        end
        sweep(1, "R6");
        // R9 / R10
        for (int k = 0; k < 5; k++) begin
            int a = (k * 7 + 3) % 16;
            int b = (a + 5) % 16;
            @(negedge clk);
            set_addr(a);
            @(negedge clk);
            phase_i[3] = 1;
            strobe_count(n);
            check("R9", n, 1);
            check("R9", wlatch_o, a);
            set_addr(b);
            strobe_count(n);
            check("R10", n, 0);
            phase_i[3] = 0;
            strobe_count(n);
            check("R10", n, 0);
            check("R10", wlatch_o, a);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule